// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames from a byte stream and places them in host memory. Software sets up a circular array of descriptors. Each descriptor names a buffer and gives that buffer's size in bytes. Software also sets up a matching array of status entries. For each frame, the block fetches the descriptor at its produce index and stores the frame bytes into that buffer. It then writes a two-word status entry and only after that advances the produce index. Software drains frames by moving the consume index after the produce index.

Software sees six 32-bit registers on a simple word-addressed write/read port. Memory is reached through a request/acknowledge master port that carries 32-bit words with byte enables. The sequencer is a single state machine with these states:

- `ST_IDLE`: waits for a frame.
- `ST_FETCH_PTR` and `ST_FETCH_CTL`: read the two descriptor words.
- `ST_RECV`: takes bytes in.
- `ST_BUF_WR`: flushes one packed word.
- `ST_WR_INFO` and `ST_WR_HASH`: write the status entry.
- `ST_ADVANCE`: bumps the produce index.
- `ST_DROP`: swallows a frame that found the ring full.

The transitions are:

- IDLE→FETCH_PTR: a frame is waiting and the ring has room.
- IDLE→DROP: a frame is waiting and the ring is full.
- FETCH_PTR→FETCH_CTL and FETCH_CTL→RECV: on each read acknowledge.
- RECV→BUF_WR: a word is complete, or the last byte arrives with bytes pending.
- RECV→WR_INFO: the last byte arrives with nothing pending.
- BUF_WR→RECV: on acknowledge, mid-frame.
- BUF_WR→WR_INFO: on acknowledge, once the frame has ended.
- WR_INFO→WR_HASH and WR_HASH→ADVANCE: on each write acknowledge.
- ADVANCE→IDLE: always.
- DROP→IDLE: on the last byte.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, every register reads zero (enable off, overrun clear, all indices zero), `s_ready` is low and `m_req` is low.
- R2: While the enable bit (register 0, bit 0) is clear, an idle block holds `s_ready` low and makes no memory request, so a waiting frame is neither taken nor dropped.
- R3: For each accepted frame, the block reads the buffer pointer at descriptor base + 8·produce. It then reads the control word at +4; bits [10:0] of the control word give the buffer size in bytes, which must be at least 1.
- R4: Stored byte k lands at buffer pointer + k, packed little-endian into 32-bit word writes. Only the lanes that hold frame bytes have their byte enables set.
- R5: The status entry at status base + 8·produce gets an info word and then a second word of zero. Info bits [10:0] hold the stored length minus one, and bit 31 is the truncation flag.
- R6: Bytes past the descriptor's buffer size are accepted but never written. The stored length equals the size and info bit 31 is set; a frame that fits has bit 31 clear.
- R7: The produce index (register 4) advances by one only after both status words have been acknowledged. It wraps from the value in register 3 (descriptor count minus one) to 0.
- R8: If (produce+1) modulo the count equals the consume index (register 5) when a frame arrives, the whole frame is taken with no memory access, the produce index is unchanged, and the overrun bit (register 0, bit 1) is set.
- R9: The overrun bit stays set until software writes register 0 with bit 1 set.
- R10: A memory request holds its address, direction and data stable until `m_ack`.
- R11: Registers 1, 2, 3 and 5 read back what was written: descriptor base, status base, count minus one, and consume index. Writes to the produce index register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Byte ends the frame |
| s_ready | output | 1 | Block takes the byte this cycle |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | Request is a write |
| m_addr | output | 32 | Byte address, word aligned |
| m_wdata | output | 32 | Write data |
| m_be | output | 4 | Byte enables for writes |
| m_rdata | input | 32 | Read data, valid with m_ack |
| m_ack | input | 1 | Request complete |

## Verification
The bench sweeps frame lengths from 1 to 12 across four descriptors whose sizes run from 5 to 8. This covers frames that fit, frames that fill the buffer exactly, and frames that overflow it, and it wraps the produce index three times. Around each frame the buffers are prefilled with a marker, so any stray write past the stored length shows up: a design that miscounted the size would overwrite bytes or clear the truncation flag. A design that mishandled wrap would write a status entry in the wrong slot. The ring is then filled to its one-free-slot limit, and the bench checks three things for the dropped frame: the produce index does not move, no memory access happens, and the overrun bit stays set until it is cleared.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int LEN_W = 11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_PTR,
        ST_FETCH_CTL,
        ST_RECV,
        ST_BUF_WR,
        ST_WR_INFO,
        ST_WR_HASH,
        ST_ADVANCE,
        ST_DROP
    } rxr_state_e;

    localparam logic [2:0] REGA_CTRL      = 3'd0;
    localparam logic [2:0] REGA_DESC_BASE = 3'd1;
    localparam logic [2:0] REGA_STAT_BASE = 3'd2;
    localparam logic [2:0] REGA_LAST_IDX  = 3'd3;
    localparam logic [2:0] REGA_PRODUCE   = 3'd4;
    localparam logic [2:0] REGA_CONSUME   = 3'd5;

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             adv,
    input  logic             set_ovr,
    output logic             rx_en,
    output logic [31:0]      desc_base,
    output logic [31:0]      stat_base,
    output logic [IDX_W-1:0] prod_idx,
    output logic             ring_full
);

    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] cons_idx;
    logic [IDX_W-1:0] prod_next;
    logic             ovr;
    logic             clr_ovr;

    assign prod_next = (prod_idx == last_idx) ? '0 : prod_idx + 1'b1;
    assign ring_full = (prod_next == cons_idx);
    assign clr_ovr   = reg_we && (reg_addr == REGA_CTRL) && reg_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en     <= 1'b0;
            ovr       <= 1'b0;
            desc_base <= '0;
            stat_base <= '0;
            last_idx  <= '0;
            cons_idx  <= '0;
            prod_idx  <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    REGA_CTRL:      rx_en     <= reg_wdata[0];
                    REGA_DESC_BASE: desc_base <= reg_wdata;
                    REGA_STAT_BASE: stat_base <= reg_wdata;
                    REGA_LAST_IDX:  last_idx  <= reg_wdata[IDX_W-1:0];
                    REGA_CONSUME:   cons_idx  <= reg_wdata[IDX_W-1:0];
                    default: ;
                endcase
            end
            if (set_ovr)      ovr <= 1'b1;
            else if (clr_ovr) ovr <= 1'b0;
            if (adv) prod_idx <= prod_next;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REGA_CTRL:      reg_rdata = {30'd0, ovr, rx_en};
            REGA_DESC_BASE: reg_rdata = desc_base;
            REGA_STAT_BASE: reg_rdata = stat_base;
            REGA_LAST_IDX:  reg_rdata = 32'(last_idx);
            REGA_PRODUCE:   reg_rdata = 32'(prod_idx);
            REGA_CONSUME:   reg_rdata = 32'(cons_idx);
            default:        reg_rdata = '0;
        endcase
    end

    // R9: overrun stays until explicitly cleared
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_ovr) |=> ovr);

    // R8: a frame is never committed into a full ring
    assert_no_adv_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !ring_full);

    // R7: index moves only on a commit pulse
    assert_prod_only_on_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !(reg_we && reg_addr == REGA_LAST_IDX)) |=> $stable(prod_idx) || $past(adv));

endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
    import rxr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             ring_full,
    input  logic [31:0]      desc_base,
    input  logic [31:0]      stat_base,
    input  logic [IDX_W-1:0] prod_idx,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    input  logic             s_last,
    output logic             s_ready,
    output logic             m_req,
    output logic             m_we,
    output logic [31:0]      m_addr,
    output logic [31:0]      m_wdata,
    output logic [3:0]       m_be,
    input  logic [31:0]      m_rdata,
    input  logic             m_ack,
    output logic             adv,
    output logic             set_ovr
);

    rxr_state_e state, nxt;

    logic [31:0]      buf_ptr;
    logic [LEN_W-1:0] size;
    logic [LEN_W-1:0] stored;
    logic [1:0]       lane;
    logic [31:0]      word;
    logic [3:0]       be;
    logic             trunc;
    logic             saw_last;

    logic [31:0]      slot_off;
    logic             keep;
    logic [3:0]       be_upd;
    logic [31:0]      info_word;

    assign slot_off  = 32'(prod_idx) << 3;
    assign keep      = (stored < size);
    assign be_upd    = be | (keep ? (4'b0001 << lane) : 4'b0000);
    assign info_word = {trunc, {(31-LEN_W){1'b0}}, stored - 1'b1};

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (rx_en && s_valid) nxt = ring_full ? ST_DROP : ST_FETCH_PTR;
            ST_FETCH_PTR: if (m_ack) nxt = ST_FETCH_CTL;
            ST_FETCH_CTL: if (m_ack) nxt = ST_RECV;
            ST_RECV: begin
                if (s_valid) begin
                    if (s_last)                  nxt = (be_upd != 4'b0000) ? ST_BUF_WR : ST_WR_INFO;
                    else if (keep && lane == 2'd3) nxt = ST_BUF_WR;
                end
            end
            ST_BUF_WR:    if (m_ack) nxt = saw_last ? ST_WR_INFO : ST_RECV;
            ST_WR_INFO:   if (m_ack) nxt = ST_WR_HASH;
            ST_WR_HASH:   if (m_ack) nxt = ST_ADVANCE;
            ST_ADVANCE:   nxt = ST_IDLE;
            ST_DROP:      if (s_valid && s_last) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        s_ready = 1'b0;
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = '0;
        m_wdata = '0;
        m_be    = 4'b0000;
        adv     = 1'b0;
        set_ovr = 1'b0;
        unique case (state)
            ST_IDLE:      set_ovr = rx_en && s_valid && ring_full;
            ST_FETCH_PTR: begin m_req = 1'b1; m_addr = desc_base + slot_off; end
            ST_FETCH_CTL: begin m_req = 1'b1; m_addr = desc_base + slot_off + 32'd4; end
            ST_RECV:      s_ready = 1'b1;
            ST_BUF_WR: begin
                m_req = 1'b1; m_we = 1'b1; m_addr = buf_ptr; m_wdata = word; m_be = be;
            end
            ST_WR_INFO: begin
                m_req = 1'b1; m_we = 1'b1; m_addr = stat_base + slot_off;
                m_wdata = info_word; m_be = 4'b1111;
            end
            ST_WR_HASH: begin
                m_req = 1'b1; m_we = 1'b1; m_addr = stat_base + slot_off + 32'd4;
                m_wdata = '0; m_be = 4'b1111;
            end
            ST_ADVANCE:   adv = 1'b1;
            ST_DROP:      s_ready = 1'b1;
            default: ;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_ptr  <= '0;
            size     <= '0;
            stored   <= '0;
            lane     <= '0;
            word     <= '0;
            be       <= '0;
            trunc    <= 1'b0;
            saw_last <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    stored   <= '0;
                    lane     <= '0;
                    word     <= '0;
                    be       <= '0;
                    trunc    <= 1'b0;
                    saw_last <= 1'b0;
                end
                ST_FETCH_PTR: if (m_ack) buf_ptr <= m_rdata;
                ST_FETCH_CTL: if (m_ack) size <= m_rdata[LEN_W-1:0];
                ST_RECV: begin
                    if (s_valid) begin
                        if (keep) begin
                            word[{lane, 3'b000} +: 8] <= s_data;
                            be     <= be_upd;
                            stored <= stored + 1'b1;
                            lane   <= lane + 1'b1;
                        end else begin
                            trunc <= 1'b1;
                        end
                        if (s_last) saw_last <= 1'b1;
                    end
                end
                ST_BUF_WR: begin
                    if (m_ack) begin
                        buf_ptr <= buf_ptr + 32'd4;
                        be      <= '0;
                        word    <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: request held steady until acknowledged
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

    // R2: disabled block stays idle
    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rx_en) |=> (state == ST_IDLE));

    // R6: stored count never passes the buffer size
    assert_trunc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV) |-> (stored <= size));

    // R7: commit only after the second status word was acknowledged
    assert_adv_after_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> ($past(state) == ST_WR_HASH));

    // R8: a full ring sends the frame to the drop path
    assert_full_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovr |=> (state == ST_DROP));

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    output logic        s_ready,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    output logic [3:0]  m_be,
    input  logic [31:0] m_rdata,
    input  logic        m_ack
);

    logic             adv;
    logic             set_ovr;
    logic             rx_en;
    logic             ring_full;
    logic [31:0]      desc_base;
    logic [31:0]      stat_base;
    logic [IDX_W-1:0] prod_idx;

    rxr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .adv       (adv),
        .set_ovr   (set_ovr),
        .rx_en     (rx_en),
        .desc_base (desc_base),
        .stat_base (stat_base),
        .prod_idx  (prod_idx),
        .ring_full (ring_full)
    );

    rxr_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .ring_full (ring_full),
        .desc_base (desc_base),
        .stat_base (stat_base),
        .prod_idx  (prod_idx),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .m_be      (m_be),
        .m_rdata   (m_rdata),
        .m_ack     (m_ack),
        .adv       (adv),
        .set_ovr   (set_ovr)
    );

    // R1: nothing is requested or accepted straight out of reset
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!m_req && !s_ready));

endmodule

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic [3:0]  m_be;
    logic [31:0] m_rdata = '0;
    logic        m_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int mem_acc  = 0;
    int ready_seen = 0;

    logic [31:0] mem [0:511];

    localparam logic [31:0] DESC_BASE = 32'h000;
    localparam logic [31:0] STAT_BASE = 32'h080;
    localparam logic [31:0] BUF_BASE  = 32'h200;

    always #2.5 clk = ~clk;

    rx_ring_writer i_rx_ring_writer (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
        .m_rdata(m_rdata), .m_ack(m_ack)
    );

    // behavioural memory, one-cycle acknowledge
    always @(posedge clk) begin
        if (m_req && !m_ack) begin
            m_ack   <= 1'b1;
            mem_acc <= mem_acc + 1;
            if (m_we) begin
                for (int b = 0; b < 4; b++)
                    if (m_be[b]) mem[m_addr[10:2]][b*8 +: 8] <= m_wdata[b*8 +: 8];
            end else begin
                m_rdata <= mem[m_addr[10:2]];
            end
        end else begin
            m_ack <= 1'b0;
        end
    end

    function automatic logic [7:0] pat(int f, int k);
        return 8'(f * 37 + k * 5 + 1);
    endfunction

    function automatic logic [7:0] get_byte(logic [31:0] a);
        return mem[a[10:2]][a[1:0]*8 +: 8];
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_frame(int f, int len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = pat(f, k); s_last = (k == len - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic wait_prod(logic [31:0] exp, output logic [31:0] got);
        got = '1;
        for (int t = 0; t < 80; t++) begin
            reg_read(3'd4, got);
            if (got == exp) break;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    always @(negedge clk) if (s_ready) ready_seen++;

    initial begin
        logic [31:0] rd;
        logic [31:0] got;
        int prod;
        int acc0;

        for (int i = 0; i < 512; i++) mem[i] = 32'h0;
        for (int i = 0; i < 4; i++) begin
            mem[(DESC_BASE >> 2) + 2*i]     = BUF_BASE + 32'(i * 64);
            mem[(DESC_BASE >> 2) + 2*i + 1] = 32'(5 + i);
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 6; a++) begin
            reg_read(3'(a), rd);
            check(rd == 0, $sformatf("R1 reg%0d after reset", a), rd, 0);
        end
        check(!s_ready && !m_req, "R1 s_ready/m_req after reset", {s_ready, m_req}, 0);

        // R2: frame waiting while disabled
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'h55; s_last = 1'b0;
        ready_seen = 0;
        repeat (20) @(negedge clk);
        check(ready_seen == 0, "R2 s_ready while disabled", ready_seen, 0);
        check(mem_acc == 0, "R2 memory access while disabled", mem_acc, 0);
        s_valid = 1'b0;
        reg_read(3'd4, rd);
        check(rd == 0, "R2 produce while disabled", rd, 0);

        // R11: configuration readback
        reg_write(3'd1, DESC_BASE);
        reg_write(3'd2, STAT_BASE);
        reg_write(3'd3, 32'd3);
        reg_write(3'd5, 32'd0);
        reg_write(3'd4, 32'd2);
        reg_read(3'd2, rd);
        check(rd == STAT_BASE, "R11 status base readback", rd, STAT_BASE);
        reg_read(3'd3, rd);
        check(rd == 3, "R11 count-1 readback", rd, 3);
        reg_read(3'd4, rd);
        check(rd == 0, "R11 produce write ignored", rd, 0);
        reg_write(3'd0, 32'd1);
        reg_read(3'd0, rd);
        check(rd == 1, "R11 ctrl readback", rd, 1);

        // R3..R7 sweep: lengths 1..12 against sizes 5..8, wrap x3
        prod = 0;
        for (int f = 0; f < 12; f++) begin
            int len = f + 1;
            int sz = 5 + prod;
            int st = (len < sz) ? len : sz;
            bit tr = (len > sz);
            logic [31:0] exp_info;
            logic [31:0] badact;
            logic [31:0] badexp;
            logic [31:0] bptr;
            bit bad;
            bptr = BUF_BASE + 32'(prod * 64);
            for (int w = 0; w < 4; w++) mem[bptr[10:2] + w] = 32'hEEEE_EEEE;
            mem[(STAT_BASE >> 2) + 2*prod]     = 32'hDEAD_BEEF;
            mem[(STAT_BASE >> 2) + 2*prod + 1] = 32'hDEAD_BEEF;
            send_frame(f, len);
            wait_prod(32'((prod + 1) % 4), got);
            check(got == 32'((prod + 1) % 4), $sformatf("R7 produce after frame %0d", f),
                  got, 32'((prod + 1) % 4));
            exp_info = (tr ? 32'h8000_0000 : 32'h0) | 32'(st - 1);
            rd = mem[(STAT_BASE >> 2) + 2*prod];
            check(rd == exp_info, $sformatf("R5 R6 info word frame %0d", f), rd, exp_info);
            rd = mem[(STAT_BASE >> 2) + 2*prod + 1];
            check(rd == 0, $sformatf("R5 second status word frame %0d", f), rd, 0);
            bad = 1'b0; badact = 0; badexp = 0;
            for (int k = 0; k < 16; k++) begin
                logic [7:0] e;
                logic [7:0] a;
                e = (k < st) ? pat(f, k) : 8'hEE;
                a = get_byte(bptr + 32'(k));
                if (a != e && !bad) begin
                    bad = 1'b1; badact = {24'd0, a}; badexp = {24'd0, e};
                end
            end
            check(!bad, $sformatf("R3 R4 R6 buffer bytes frame %0d", f), badact, badexp);
            prod = (prod + 1) % 4;
            reg_write(3'd5, 32'(prod));
        end

        // R8: fill the ring, leaving one slot free
        for (int f = 20; f < 23; f++) begin
            send_frame(f, 4);
            wait_prod(32'((prod + 1) % 4), got);
            prod = (prod + 1) % 4;
        end
        check(got == 3, "R8 produce after filling", got, 3);
        repeat (4) @(negedge clk);
        acc0 = mem_acc;
        mem[(STAT_BASE >> 2) + 6] = 32'hDEAD_BEEF;
        send_frame(30, 6);
        repeat (20) @(negedge clk);
        reg_read(3'd4, rd);
        check(rd == 3, "R8 produce unchanged on drop", rd, 3);
        check(mem_acc == acc0, "R8 no memory access on drop", mem_acc, acc0);
        check(mem[(STAT_BASE >> 2) + 6] == 32'hDEAD_BEEF, "R8 status slot untouched",
              mem[(STAT_BASE >> 2) + 6], 32'hDEAD_BEEF);
        reg_read(3'd0, rd);
        check(rd == 3, "R8 overrun set", rd, 3);

        // R9: sticky until write-one
        reg_write(3'd0, 32'd1);
        reg_read(3'd0, rd);
        check(rd == 3, "R9 overrun kept without clear bit", rd, 3);
        reg_write(3'd0, 32'd3);
        reg_read(3'd0, rd);
        check(rd == 1, "R9 overrun cleared", rd, 1);

        // ring drained: next frame goes to slot 3 and wraps to 0
        reg_write(3'd5, 32'd3);
        send_frame(40, 3);
        wait_prod(32'd0, got);
        check(got == 0, "R7 wrap after drain", got, 0);
        rd = mem[(STAT_BASE >> 2) + 6];
        check(rd == 32'd2, "R5 info after drain", rd, 2);
        check(get_byte(BUF_BASE + 32'(3*64) + 2) == pat(40, 2), "R4 byte after drain",
              {24'd0, get_byte(BUF_BASE + 32'(3*64) + 2)}, {24'd0, pat(40, 2)});

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule